// File: doc/BRIEF.md
# Multi-Mode Bus Event Trigger Sequencer

This block watches four per-cycle event-match lines (A, B, C, D), each gated by its own enable bit. When the event pattern chosen by the mode input is complete, it raises a single-cycle trigger pulse. The mode input selects one of five patterns:
- any single enabled event;
- a two-phase pattern, where A or B is followed later by C or D;
- the ordered sequence A, B, C, in which D aborts progress;
- the strict ordered sequence A, B, C, D;
- the Nth cycle on which any enabled event matches, with N programmable.

Software or a debug controller pulses `arm_i` to clear the sequencer and start a search. The sequencer then reports whether it is idle, searching or fired, and how many ordered steps it has completed. The comparators that produce the match lines and any trace storage sit outside this block.

Top module: `trig_seq_top`

## Requirements
- R1: After reset, `status_o` is 0 (idle), `stage_o` is 0 and `trig_o` is low. While the block is idle, event inputs never raise `trig_o` or change the status.
- R2: A cycle with `arm_i` high makes `status_o` read 1 (armed), with `stage_o` 0 and `trig_o` low, on the next cycle. Events present in the arm cycle are ignored, and arming takes priority over everything else.
- R3: The trigger asserts for exactly one cycle, in the cycle after the event cycle that completes the pattern. `status_o` then reads 2 (fired) and holds until the next arm, with no further pulse.
- R4: With `mode_i` = 0, the trigger fires on the first cycle in which any enabled event matches. Matches on disabled events are ignored. Event A is bit 0 of the event and enable buses, B is bit 1, C is bit 2 and D is bit 3.
- R5: With `mode_i` = 1, an enabled A or B sets stage 1. After that, an enabled C or D in a later cycle fires. An A and a C in the same cycle at stage 0 only advance the stage.
- R6: With `mode_i` = 2, A, B and C must occur in order, with stage 1 after A and stage 2 after B. An enabled D returns the stage to 0, and it wins over a simultaneous C. When D is disabled, the mode is a plain A, B, C sequence.
- R7: With `mode_i` = 3, the sequence is A, B, C, D in order, with `stage_o` counting completed steps up to 3. An event other than the next expected one does not advance the stage.
- R8: In the ordered modes, the stage advances at most one step per cycle, even when several events match at once.
- R9: With `mode_i` = 4, each cycle with at least one enabled match counts once. The trigger fires on the cycle that makes the count equal `n_i`, and an `n_i` of 0 acts as 1.
- R10: `mode_i` values 5 to 7 never fire.
- R11: A mode whose required event is disabled never fires: two-phase with C and D disabled, and four-step with D disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| arm_i | input | 1 | Synchronous clear and arm |
| mode_i | input | 3 | Trigger pattern select |
| evt_en_i | input | 4 | Per-event enable, A at bit 0 |
| evt_hit_i | input | 4 | Per-cycle event match, A at bit 0 |
| n_i | input | CNT_W | Occurrence target for mode 4 |
| trig_o | output | 1 | One-cycle trigger pulse |
| status_o | output | 2 | 0 idle, 1 armed, 2 fired |
| stage_o | output | 2 | Completed ordered steps |

## Verification
The bench drives all four events at once in the four-step mode. A sequencer that jumps several stages per cycle would fire on the second such cycle instead of the fourth. It places D together with the final C in the abort mode, where a design with the wrong priority would fire. It also disables a required event, which a design that ignored enables would let through. In the Nth-event mode it programs N to 0 and checks that the first match fires, where a naive counter would wait for a wrap. It also mixes disabled hits and idle cycles into the count. Finally, it arms while an event is present and after a fire, and it checks that a fired sequencer does not produce a second pulse.

// File: rtl/trig_pkg.sv
package trig_pkg;
  typedef enum logic [2:0] {
    MODE_ANY       = 3'd0,
    MODE_TWO_PHASE = 3'd1,
    MODE_ABC_ABORT = 3'd2,
    MODE_ABCD      = 3'd3,
    MODE_NTH       = 3'd4
  } mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_FIRED = 2'd2
  } status_e;

  localparam int unsigned NUM_EVT = 4;
  localparam int unsigned EVT_A   = 0;
  localparam int unsigned EVT_B   = 1;
  localparam int unsigned EVT_C   = 2;
  localparam int unsigned EVT_D   = 3;
endpackage

// File: rtl/trig_evt_mask.sv
module trig_evt_mask
  import trig_pkg::*;
(
  input  logic [NUM_EVT-1:0] hit_i,
  input  logic [NUM_EVT-1:0] en_i,
  output logic [NUM_EVT-1:0] match_o,
  output logic               any_o,
  output logic               ab_o,
  output logic               cd_o
);
  for (genvar g = 0; g < NUM_EVT; g++) begin : g_mask
    assign match_o[g] = hit_i[g] & en_i[g];
  end

  assign any_o = |match_o;
  assign ab_o  = match_o[EVT_A] | match_o[EVT_B];
  assign cd_o  = match_o[EVT_C] | match_o[EVT_D];
endmodule

// File: rtl/trig_order_fsm.sv
module trig_order_fsm
  import trig_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               run_i,
  input  logic [2:0]         mode_i,
  input  logic [NUM_EVT-1:0] match_i,
  input  logic               any_i,
  input  logic               ab_i,
  input  logic               cd_i,
  output logic [1:0]         stage_o,
  output logic               fire_o
);
  logic [1:0] stage_q, stage_d;

  always_comb begin
    stage_d = stage_q;
    fire_o  = 1'b0;
    if (run_i) begin
      case (mode_i)
        MODE_ANY: fire_o = any_i;
        MODE_TWO_PHASE: begin
          if (stage_q == 2'd0) begin
            if (ab_i) stage_d = 2'd1;
          end else if (cd_i) begin
            fire_o = 1'b1;
          end
        end
        MODE_ABC_ABORT: begin
          // abort outranks any forward step
          if (match_i[EVT_D]) begin
            stage_d = 2'd0;
          end else begin
            case (stage_q)
              2'd0:    if (match_i[EVT_A]) stage_d = 2'd1;
              2'd1:    if (match_i[EVT_B]) stage_d = 2'd2;
              default: if (match_i[EVT_C]) fire_o = 1'b1;
            endcase
          end
        end
        MODE_ABCD: begin
          case (stage_q)
            2'd0:    if (match_i[EVT_A]) stage_d = 2'd1;
            2'd1:    if (match_i[EVT_B]) stage_d = 2'd2;
            2'd2:    if (match_i[EVT_C]) stage_d = 2'd3;
            default: if (match_i[EVT_D]) fire_o = 1'b1;
          endcase
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    stage_q <= 2'd0;
    else if (clr_i) stage_q <= 2'd0;
    else            stage_q <= stage_d;
  end

  assign stage_o = stage_q;
endmodule

// File: rtl/trig_occ_cnt.sv
module trig_occ_cnt #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             run_i,
  input  logic             inc_i,
  input  logic [CNT_W-1:0] n_i,
  output logic             fire_o
);
  localparam int unsigned EXT_W = CNT_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] tgt;
  logic [EXT_W-1:0] cnt_nxt;

  assign tgt     = (n_i == '0) ? CNT_W'(1) : n_i;
  assign cnt_nxt = {1'b0, cnt_q} + EXT_W'(1);
  assign fire_o  = run_i & inc_i & (cnt_nxt == {1'b0, tgt});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (clr_i)           cnt_q <= '0;
    else if (run_i && inc_i)  cnt_q <= cnt_nxt[CNT_W-1:0];
  end
endmodule

// File: rtl/trig_seq_top.sv
module trig_seq_top
  import trig_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               arm_i,
  input  logic [2:0]         mode_i,
  input  logic [NUM_EVT-1:0] evt_en_i,
  input  logic [NUM_EVT-1:0] evt_hit_i,
  input  logic [CNT_W-1:0]   n_i,
  output logic               trig_o,
  output logic [1:0]         status_o,
  output logic [1:0]         stage_o
);
  status_e            status_q;
  logic               trig_q;
  logic [NUM_EVT-1:0] match;
  logic               any_m, ab_m, cd_m;
  logic               run, seq_fire, cnt_fire, fire, clr;

  assign run  = (status_q == ST_ARMED) && !arm_i;
  assign fire = seq_fire | cnt_fire;
  assign clr  = arm_i | fire;

  trig_evt_mask u_mask (
    .hit_i   (evt_hit_i),
    .en_i    (evt_en_i),
    .match_o (match),
    .any_o   (any_m),
    .ab_o    (ab_m),
    .cd_o    (cd_m)
  );

  trig_order_fsm u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr),
    .run_i   (run),
    .mode_i  (mode_i),
    .match_i (match),
    .any_i   (any_m),
    .ab_i    (ab_m),
    .cd_i    (cd_m),
    .stage_o (stage_o),
    .fire_o  (seq_fire)
  );

  trig_occ_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .run_i  (run && (mode_i == MODE_NTH)),
    .inc_i  (any_m),
    .n_i    (n_i),
    .fire_o (cnt_fire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= ST_IDLE;
      trig_q   <= 1'b0;
    end else if (arm_i) begin
      status_q <= ST_ARMED;
      trig_q   <= 1'b0;
    end else if (fire) begin
      status_q <= ST_FIRED;
      trig_q   <= 1'b1;
    end else begin
      trig_q   <= 1'b0;
    end
  end

  assign trig_o   = trig_q;
  assign status_o = status_q;
endmodule

// File: rtl/trig_seq_chk.sv
module trig_seq_chk
  import trig_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               arm_i,
  input logic [2:0]         mode_i,
  input logic [NUM_EVT-1:0] evt_en_i,
  input logic [NUM_EVT-1:0] evt_hit_i,
  input logic               trig_o,
  input logic [1:0]         status_o,
  input logic [1:0]         stage_o
);
  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o == ST_IDLE && !arm_i) |=> (status_o == ST_IDLE && !trig_o));

  p_arm_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_i |=> (status_o == ST_ARMED && stage_o == 2'd0 && !trig_o));

  p_pulse_one_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |=> !trig_o);

  p_pulse_fired_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |-> status_o == ST_FIRED);

  p_fired_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o == ST_FIRED && !arm_i) |=> (status_o == ST_FIRED && !trig_o));

  p_abort_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o == ST_ARMED && !arm_i && mode_i == MODE_ABC_ABORT &&
     evt_hit_i[EVT_D] && evt_en_i[EVT_D]) |=> (!trig_o && stage_o == 2'd0));

  p_one_step_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o == ST_ARMED && !arm_i) |=>
      (stage_o == $past(stage_o) || stage_o == $past(stage_o) + 2'd1 || stage_o == 2'd0));

  p_reserved_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o == ST_ARMED && !arm_i && mode_i > 3'd4) |=> !trig_o);

  p_status_legal_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o != 2'd3);
endmodule

bind trig_seq_top trig_seq_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .arm_i     (arm_i),
  .mode_i    (mode_i),
  .evt_en_i  (evt_en_i),
  .evt_hit_i (evt_hit_i),
  .trig_o    (trig_o),
  .status_o  (status_o),
  .stage_o   (stage_o)
);

// File: tb/tb_trig_seq_top.sv
module tb_trig_seq_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        arm = 1'b0;
  logic [2:0]  mode = 3'd0;
  logic [3:0]  en = 4'h0;
  logic [3:0]  hit = 4'h0;
  logic [15:0] n = 16'd0;
  logic        trig;
  logic [1:0]  status;
  logic [1:0]  stage;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  trig_seq_top dut (
    .clk_i(clk), .rst_ni(rst_n), .arm_i(arm), .mode_i(mode),
    .evt_en_i(en), .evt_hit_i(hit), .n_i(n),
    .trig_o(trig), .status_o(status), .stage_o(stage)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // drive one cycle of events, return at the following negedge
  task automatic cyc(input logic [3:0] h);
    hit = h;
    @(negedge clk);
    hit = 4'h0;
  endtask

  task automatic do_arm(input logic [2:0] m, input logic [3:0] e);
    mode = m; en = e; arm = 1'b1;
    @(negedge clk);
    arm = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 status", status, 0);
    chk("R1 trig", trig, 0);
    chk("R1 stage", stage, 0);
    mode = 3'd0; en = 4'hF;
    cyc(4'hF);
    chk("R1 idle trig", trig, 0);
    chk("R1 idle status", status, 0);
  endtask

  task automatic t_any;
    do_arm(3'd0, 4'b0100);
    chk("R2 armed", status, 1);
    cyc(4'b1011);
    chk("R4 disabled ignored", trig, 0);
    cyc(4'b0100);
    chk("R4 fire", trig, 1);
    chk("R3 fired status", status, 2);
    cyc(4'b0100);
    chk("R3 no second pulse", trig, 0);
    chk("R3 fired holds", status, 2);
    mode = 3'd0; en = 4'b0100; hit = 4'b0100; arm = 1'b1;
    @(negedge clk);
    arm = 1'b0; hit = 4'h0;
    chk("R2 arm priority trig", trig, 0);
    chk("R2 arm priority status", status, 1);
  endtask

  task automatic t_two_phase;
    do_arm(3'd1, 4'hF);
    cyc(4'b0101);
    chk("R5 same-cycle A,C advance only", stage, 1);
    chk("R5 no early fire", trig, 0);
    cyc(4'b0100);
    chk("R5 fire", trig, 1);
    do_arm(3'd1, 4'b0011);
    cyc(4'b0010);
    chk("R11 phase one", stage, 1);
    cyc(4'b1100);
    cyc(4'b0100);
    chk("R11 C/D disabled", trig, 0);
    chk("R11 still armed", status, 1);
  endtask

  task automatic t_abc;
    do_arm(3'd2, 4'hF);
    cyc(4'b0001);
    chk("R6 stage A", stage, 1);
    cyc(4'b0010);
    chk("R6 stage B", stage, 2);
    cyc(4'b1000);
    chk("R6 D abort", stage, 0);
    cyc(4'b0001);
    cyc(4'b0010);
    cyc(4'b1100);
    chk("R6 D beats C trig", trig, 0);
    chk("R6 D beats C stage", stage, 0);
    cyc(4'b0001);
    cyc(4'b0010);
    cyc(4'b0100);
    chk("R6 fire", trig, 1);
    do_arm(3'd2, 4'b0111);
    cyc(4'b0001);
    cyc(4'b0010);
    cyc(4'b1000);
    chk("R6 D disabled no abort", stage, 2);
    cyc(4'b0100);
    chk("R6 plain sequence fire", trig, 1);
  endtask

  task automatic t_abcd;
    do_arm(3'd3, 4'hF);
    cyc(4'hF);
    chk("R8 one step", stage, 1);
    cyc(4'hF);
    chk("R8 two steps", stage, 2);
    cyc(4'hF);
    chk("R8 three steps", stage, 3);
    chk("R8 no early fire", trig, 0);
    cyc(4'hF);
    chk("R7 fire", trig, 1);
    do_arm(3'd3, 4'hF);
    cyc(4'b0010);
    chk("R7 B first ignored", stage, 0);
    cyc(4'b0001);
    cyc(4'b0100);
    chk("R7 C out of order", stage, 1);
    do_arm(3'd3, 4'b0111);
    cyc(4'b0001);
    cyc(4'b0010);
    cyc(4'b0100);
    chk("R11 reached stage 3", stage, 3);
    cyc(4'b1000);
    chk("R11 D disabled", trig, 0);
  endtask

  task automatic t_nth;
    n = 16'd3;
    do_arm(3'd4, 4'b0001);
    cyc(4'b0001);
    cyc(4'b0000);
    cyc(4'b0010);
    cyc(4'b0001);
    chk("R9 two counted", trig, 0);
    cyc(4'b0001);
    chk("R9 third fires", trig, 1);
    n = 16'd2;
    do_arm(3'd4, 4'hF);
    cyc(4'hF);
    chk("R9 one per cycle", trig, 0);
    cyc(4'hF);
    chk("R9 second cycle fires", trig, 1);
    n = 16'd0;
    do_arm(3'd4, 4'b0001);
    cyc(4'b0001);
    chk("R9 N=0 as 1", trig, 1);
  endtask

  task automatic t_reserved;
    for (int m = 5; m < 8; m++) begin
      do_arm(3'(m), 4'hF);
      cyc(4'hF);
      cyc(4'hF);
      chk("R10 reserved trig", trig, 0);
      chk("R10 reserved status", status, 1);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_any;
    t_two_phase;
    t_abc;
    t_abcd;
    t_nth;
    t_reserved;
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule